// File: doc/BRIEF.md
# Two-Bank SDRAM Command Watcher

This block observes the command pins of a two-bank synchronous DRAM on every rising clock edge. It turns each sampled cycle into one command code. It keeps a model of which bank is open and which row it holds, and it tracks any burst that closes its bank by itself when the burst ends. Commands that break the ordering rules produce a one-cycle violation pulse and a reason code. The block also derives two data-mask outputs from DQM: a write mask that applies to the same cycle, and a read output-disable that applies two cycles later.

All outputs are registered. A value that depends on the pins sampled at edge k is visible just after edge k. Power-saving modes entered by dropping CKE are tracked as a state. Commands sampled while the clock is disabled are ignored.

Top module: `sdram_cmd_watch`

## Requirements
- R1: With chip select high the cycle decodes as no-operation. With chip select low, {ras_n,cas_n,we_n} decodes as follows: 000 mode set (code 1), 001 refresh (2), 011 activate (4), 101 read (5), 100 write (6), 110 burst stop (7), 010 precharge (8), and 111 no-operation (0). A refresh pattern sampled with CKE high in the running state reports code 2. cmd_o shows the code one edge after sampling.
- R2: A legal activate opens bank A when ba=0 and bank B when ba=1. bank_act_o bit 0 is bank A and bit 1 is bank B. The bank's row output takes {a_ap, addr}.
- R3: A legal precharge with a_ap low closes only the bank selected by ba. With a_ap high it closes both banks, whatever ba is.
- R4: Mode set with any bank open gives reason code 1. Refresh or self-refresh entry with any bank open gives reason code 2. Either illegal command has no effect: it starts no command gap, and it enters no self refresh.
- R5: After a legal mode set, any command other than no-operation in the next two enabled cycles gives reason code 3 and is ignored. On the third enabled cycle, commands act normally. The mode set latches burst length from addr[2:0]: 0→1, 1→2, 2→4, and 3 to 7→8. After reset the burst length is 1.
- R6: A legal read or write with a_ap high closes its bank at the edge that lies burst-length enabled cycles after the command edge.
- R7: A read or write to a bank whose self-closing burst is still running gives reason code 4 and is ignored. A read or write to the other bank is not flagged.
- R8: wr_mask_o equals DQM sampled at the latest edge (write latency 0).
- R9: rd_hiz_o equals DQM sampled two edges before the latest edge (read latency 2).
- R10: pwr_o reports the power state: 0 running, 1 clock suspend, 2 power-down, 3 self refresh. In the running state, CKE sampled low with a refresh pattern and both banks idle enters 3 and reports code 3. Otherwise, CKE sampled low enters 2 if both banks are idle, or 1 if a bank is open. While CKE stays low, commands report 0 and have no effect. CKE sampled high returns to 0, and the command on that exit cycle is ignored.
- R11: After synchronous reset, every output is 0 and the burst length is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | 1 | Bank select |
| a_ap | input | 1 | Address bit used as auto-close / both-banks flag and row MSB |
| addr | input | ADDR_W | Low address bits |
| cmd_o | output | 4 | Decoded command code |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Violation reason |
| bank_act_o | output | 2 | Open flag per bank |
| row_a_o | output | ADDR_W+1 | Open row of bank A |
| row_b_o | output | ADDR_W+1 | Open row of bank B |
| pwr_o | output | 2 | Power state |
| wr_mask_o | output | 1 | Write data mask for the latest cycle |
| rd_hiz_o | output | 1 | Read output disable |

## Verification
A bank flag that is stale shows on bank_act_o right after the next edge. It also shows a few edges later as a wrong reason code 1 or 2 on the next mode set or refresh. A burst counter that is off by one closes the bank one edge early or late at the burst boundary, and it hides or invents a code 4 on a repeated read. A wrong command-gap count shows within two enabled cycles of a mode set as a missing or spurious code 3. A DQM pipe of the wrong depth shows on rd_hiz_o two edges after the mask pulse.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int NBANK   = 2;
    localparam int MRS_GAP = 2;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_MRS   = 4'd1,
        CMD_AREF  = 4'd2,
        CMD_SREF  = 4'd3,
        CMD_ACT   = 4'd4,
        CMD_READ  = 4'd5,
        CMD_WRITE = 4'd6,
        CMD_BST   = 4'd7,
        CMD_PRE   = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_SUSP = 2'd1,
        PS_PDN  = 2'd2,
        PS_SELF = 2'd3
    } pwr_e;

    typedef enum logic [2:0] {
        VC_NONE        = 3'd0,
        VC_MRS_BUSY    = 3'd1,
        VC_REF_BUSY    = 3'd2,
        VC_LOCKOUT     = 3'd3,
        VC_AP_CONFLICT = 3'd4
    } vcode_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Burst length selected by the low mode bits.
    function automatic logic [3:0] burst_len(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // Raw pin pattern to command, ignoring clock enable.
    function automatic cmd_e pin_cmd(input pins_t p);
        if (p.cs_n) return CMD_NOP;
        case ({p.ras_n, p.cas_n, p.we_n})
            3'b000:  return CMD_MRS;
            3'b001:  return CMD_AREF;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_READ;
            3'b100:  return CMD_WRITE;
            3'b110:  return CMD_BST;
            3'b010:  return CMD_PRE;
            default: return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  pins_t pins_i,
    input  logic  cke_i,
    input  pwr_e  ps_i,
    output cmd_e  eff_o,
    output logic  run_o
);
    cmd_e raw;

    assign raw   = pin_cmd(pins_i);
    assign run_o = (ps_i == PS_RUN) && cke_i;

    always_comb begin
        if (run_o)
            eff_o = raw;
        else if (ps_i == PS_RUN && raw == CMD_AREF)
            eff_o = CMD_SREF;          // refresh pattern on a falling CKE
        else
            eff_o = CMD_NOP;
    end
endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track #(
    parameter int ROW_W = 9,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             open_i,
    input  logic             close_i,
    input  logic             ap_i,
    input  logic [CNT_W-1:0] bl_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o,
    output logic             busy_o,
    output logic [ROW_W-1:0] row_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            cnt_q    <= '0;
            row_o    <= '0;
        end else if (close_i) begin
            active_o <= 1'b0;
            cnt_q    <= '0;
        end else if (open_i) begin
            active_o <= 1'b1;
            row_o    <= row_i;
        end else if (ap_i) begin
            cnt_q <= bl_i;
        end else if (adv_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1))
                active_o <= 1'b0;
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdc_dqm_pipe.sv
module sdc_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm_i,
    output logic wr_mask_o,
    output logic rd_hiz_o
);
    logic [RD_LAT:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q[0] <= 1'b0;
        else     sr_q[0] <= dqm_i;
    end

    for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sr_q[i] <= 1'b0;
            else     sr_q[i] <= sr_q[i-1];
        end
    end

    assign wr_mask_o = sr_q[0];
    assign rd_hiz_o  = sr_q[RD_LAT];
endmodule

// File: rtl/sdram_cmd_watch.sv
module sdram_cmd_watch
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int RD_LAT = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              dqm,
    input  logic              ba,
    input  logic              a_ap,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_o,
    output logic              viol_o,
    output logic [2:0]        viol_code_o,
    output logic [1:0]        bank_act_o,
    output logic [ADDR_W:0]   row_a_o,
    output logic [ADDR_W:0]   row_b_o,
    output logic [1:0]        pwr_o,
    output logic              wr_mask_o,
    output logic              rd_hiz_o
);
    localparam int ROW_W  = ADDR_W + 1;
    localparam int LOCK_W = $clog2(MRS_GAP + 1);

    pins_t              pins;
    cmd_e               eff;
    logic               run_cyc;
    pwr_e               ps_q, ps_d;
    vcode_e             vc;
    logic               ok, all_idle;
    logic [LOCK_W-1:0]  lock_q;
    logic [CNT_W-1:0]   bl_q;
    logic [NBANK-1:0]   act_v, busy_v;
    logic [ROW_W-1:0]   row_v [NBANK];
    logic               is_rw;

    assign pins = {cs_n, ras_n, cas_n, we_n};

    sdc_cmd_decode u_dec (
        .pins_i (pins),
        .cke_i  (cke),
        .ps_i   (ps_q),
        .eff_o  (eff),
        .run_o  (run_cyc)
    );

    assign all_idle = ~|act_v;
    assign is_rw    = (eff == CMD_READ) || (eff == CMD_WRITE);

    // Legality check, command gap has priority over bank-state rules.
    always_comb begin
        vc = VC_NONE;
        if (eff != CMD_NOP && lock_q != '0)
            vc = VC_LOCKOUT;
        else begin
            case (eff)
                CMD_MRS:             if (!all_idle) vc = VC_MRS_BUSY;
                CMD_AREF, CMD_SREF:  if (!all_idle) vc = VC_REF_BUSY;
                CMD_READ, CMD_WRITE: if (busy_v[ba]) vc = VC_AP_CONFLICT;
                default: ;
            endcase
        end
    end
    assign ok = (vc == VC_NONE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel = (ba == 1'(b));
        sdc_bank_track #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .adv_i    (run_cyc),
            .open_i   (ok && eff == CMD_ACT && sel),
            .close_i  (ok && eff == CMD_PRE && (a_ap || sel)),
            .ap_i     (ok && is_rw && a_ap && sel),
            .bl_i     (bl_q),
            .row_i    ({a_ap, addr}),
            .active_o (act_v[b]),
            .busy_o   (busy_v[b]),
            .row_o    (row_v[b])
        );
    end

    // Power state on CKE transitions.
    always_comb begin
        ps_d = ps_q;
        case (ps_q)
            PS_RUN: begin
                if (!cke) begin
                    if (eff == CMD_SREF && ok) ps_d = PS_SELF;
                    else if (all_idle)         ps_d = PS_PDN;
                    else                       ps_d = PS_SUSP;
                end
            end
            default: if (cke) ps_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q        <= PS_RUN;
            lock_q      <= '0;
            bl_q        <= CNT_W'(burst_len(3'd0));
            cmd_o       <= '0;
            viol_o      <= 1'b0;
            viol_code_o <= '0;
        end else begin
            ps_q        <= ps_d;
            cmd_o       <= eff;
            viol_o      <= !ok;
            viol_code_o <= vc;
            if (ok && eff == CMD_MRS) begin
                lock_q <= LOCK_W'(MRS_GAP);
                bl_q   <= CNT_W'(burst_len(addr[2:0]));
            end else if (run_cyc && lock_q != '0) begin
                lock_q <= lock_q - LOCK_W'(1);
            end
        end
    end

    sdc_dqm_pipe #(.RD_LAT(RD_LAT)) u_dqm (
        .clk       (clk),
        .rst       (rst),
        .dqm_i     (dqm),
        .wr_mask_o (wr_mask_o),
        .rd_hiz_o  (rd_hiz_o)
    );

    assign bank_act_o = act_v;
    assign row_a_o    = row_v[0];
    assign row_b_o    = row_v[1];
    assign pwr_o      = ps_q;
endmodule

// File: rtl/sdram_cmd_watch_chk.sv
module sdram_cmd_watch_chk
    import sdc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_o,
    input logic       viol_o,
    input logic [2:0] viol_code_o,
    input logic [1:0] bank_act_o,
    input logic [1:0] pwr_o,
    input logic       wr_mask_o,
    input logic       rd_hiz_o
);
    p_open_row_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT && !viol_o) |-> (bank_act_o != 2'b00));

    p_mrs_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == VC_MRS_BUSY) |-> (cmd_o == CMD_MRS));

    p_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_o == CMD_MRS && !viol_o) && cmd_o != CMD_NOP)
            |-> (viol_code_o == VC_LOCKOUT));

    p_conflict_r7: assert property (@(posedge clk) disable iff (rst)
        (viol_code_o == VC_AP_CONFLICT) |-> (cmd_o == CMD_READ || cmd_o == CMD_WRITE));

    p_rd_delay_r9: assert property (@(posedge clk) disable iff (rst)
        rd_hiz_o == $past(wr_mask_o, 2));

    p_self_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_o == PS_SELF) |-> (bank_act_o == 2'b00));

    p_lowpwr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_o != PS_RUN) |-> (cmd_o == CMD_NOP || cmd_o == CMD_SREF));
endmodule

bind sdram_cmd_watch sdram_cmd_watch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_o       (cmd_o),
    .viol_o      (viol_o),
    .viol_code_o (viol_code_o),
    .bank_act_o  (bank_act_o),
    .pwr_o       (pwr_o),
    .wr_mask_o   (wr_mask_o),
    .rd_hiz_o    (rd_hiz_o)
);

// File: tb/sdram_cmd_watch_tb_top.sv
module sdram_cmd_watch_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int K_DES = 0, K_MRS = 1, K_REF = 2, K_ACT = 3, K_RD = 4,
                   K_WR = 5, K_BST = 6, K_PRE = 7, K_NOP = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cke, cs_n, ras_n, cas_n, we_n, dqm, ba, a_ap;
    logic [7:0] addr;
    logic [3:0] cmd_o;
    logic       viol_o;
    logic [2:0] viol_code_o;
    logic [1:0] bank_act_o;
    logic [8:0] row_a_o, row_b_o;
    logic [1:0] pwr_o;
    logic       wr_mask_o, rd_hiz_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    bit m_act [2];
    int m_row [2];
    int m_cnt [2];
    int m_bl, m_lock, m_ps, m_cmd, m_code;
    bit d0, d1, d2;

    always #10 clk = ~clk;

    sdram_cmd_watch dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .a_ap(a_ap),
        .addr(addr), .cmd_o(cmd_o), .viol_o(viol_o), .viol_code_o(viol_code_o),
        .bank_act_o(bank_act_o), .row_a_o(row_a_o), .row_b_o(row_b_o),
        .pwr_o(pwr_o), .wr_mask_o(wr_mask_o), .rd_hiz_o(rd_hiz_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int raw_code(input int k);
        case (k)
            K_MRS: return 1;
            K_REF: return 2;
            K_ACT: return 4;
            K_RD:  return 5;
            K_WR:  return 6;
            K_BST: return 7;
            K_PRE: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int bl_of(input int c);
        if (c == 0) return 1;
        if (c == 1) return 2;
        if (c == 2) return 4;
        return 8;
    endfunction

    task automatic set_pins(input int k);
        logic [3:0] p;
        case (k)
            K_MRS: p = 4'b0000;
            K_REF: p = 4'b0001;
            K_ACT: p = 4'b0011;
            K_RD:  p = 4'b0101;
            K_WR:  p = 4'b0100;
            K_BST: p = 4'b0110;
            K_PRE: p = 4'b0010;
            K_NOP: p = 4'b0111;
            default: p = 4'b1111;
        endcase
        {cs_n, ras_n, cas_n, we_n} = p;
    endtask

    task automatic model_update(input int k, input bit c, input bit b,
                                input bit ap, input int a, input bit dq);
        int  rc, eff, code;
        bit  idle, run, okk;
        rc   = raw_code(k);
        run  = (m_ps == 0) && c;
        if (run) eff = rc;
        else if (m_ps == 0 && rc == 2) eff = 3;
        else eff = 0;
        idle = !m_act[0] && !m_act[1];
        code = 0;
        if (eff != 0 && m_lock > 0) code = 3;
        else if (eff == 1 && !idle) code = 1;
        else if ((eff == 2 || eff == 3) && !idle) code = 2;
        else if ((eff == 5 || eff == 6) && m_cnt[b] > 0) code = 4;
        okk = (code == 0);
        if (m_ps == 0 && !c) m_ps = (eff == 3 && okk) ? 3 : (idle ? 2 : 1);
        else if (m_ps != 0 && c) m_ps = 0;
        for (int i = 0; i < 2; i++) begin
            bit sel;
            sel = (int'(b) == i);
            if (okk && eff == 8 && (ap || sel)) begin
                m_act[i] = 0; m_cnt[i] = 0;
            end else if (okk && eff == 4 && sel) begin
                m_act[i] = 1; m_row[i] = (int'(ap) << 8) | (a & 255);
            end else if (okk && (eff == 5 || eff == 6) && ap && sel) begin
                m_cnt[i] = m_bl;
            end else if (run && m_cnt[i] > 0) begin
                m_cnt[i]--;
                if (m_cnt[i] == 0) m_act[i] = 0;
            end
        end
        if (okk && eff == 1) begin
            m_lock = 2;
            m_bl   = bl_of(a & 7);
        end else if (run && m_lock > 0) m_lock--;
        m_cmd  = eff;
        m_code = code;
        d2 = d1; d1 = d0; d0 = dq;
    endtask

    task automatic compare_all();
        chk("R1 cmd", int'(cmd_o), m_cmd);
        chk("R4 R5 R7 viol", int'(viol_o), int'(m_code != 0));
        chk("R4 R5 R7 code", int'(viol_code_o), m_code);
        chk("R2 R3 R6 banks", int'(bank_act_o), int'({m_act[1], m_act[0]}));
        chk("R2 row_a", int'(row_a_o), m_row[0]);
        chk("R2 row_b", int'(row_b_o), m_row[1]);
        chk("R10 pwr", int'(pwr_o), m_ps);
        chk("R8 wr_mask", int'(wr_mask_o), int'(d0));
        chk("R9 rd_hiz", int'(rd_hiz_o), int'(d2));
    endtask

    // Called at a falling edge; leaves the bench at the next falling edge.
    task automatic step(input int k, input bit c, input bit b, input bit ap,
                        input int a, input bit dq);
        set_pins(k);
        cke = c; ba = b; a_ap = ap; addr = a[7:0]; dqm = dq;
        @(posedge clk);
        model_update(k, c, b, ap, a, dq);
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20511));
        rst = 1'b1;
        set_pins(K_NOP);
        cke = 1'b1; dqm = 1'b0; ba = 1'b0; a_ap = 1'b0; addr = '0;
        for (int i = 0; i < 2; i++) begin m_act[i] = 0; m_row[i] = 0; m_cnt[i] = 0; end
        m_bl = 1; m_lock = 0; m_ps = 0; m_cmd = 0; m_code = 0;
        d0 = 0; d1 = 0; d2 = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        chk("R11 cmd", int'(cmd_o), 0);
        chk("R11 viol", int'(viol_o), 0);
        chk("R11 code", int'(viol_code_o), 0);
        chk("R11 banks", int'(bank_act_o), 0);
        chk("R11 rows", int'(row_a_o | row_b_o), 0);
        chk("R11 pwr", int'(pwr_o), 0);
        chk("R11 masks", int'({wr_mask_o, rd_hiz_o}), 0);

        // R1: deselect and auto refresh
        step(K_DES, 1, 0, 0, 0, 0);
        chk("R1 deselect", int'(cmd_o), 0);
        step(K_REF, 1, 0, 0, 0, 0);
        chk("R1 auto refresh", int'(cmd_o), 2);

        // R2: open both banks
        step(K_ACT, 1, 1, 1, 'hA5, 0);
        chk("R2 row B", int'(row_b_o), 'h1A5);
        chk("R2 bank B open", int'(bank_act_o), 2);
        step(K_ACT, 1, 0, 0, 'h33, 0);
        chk("R2 bank A open", int'(bank_act_o), 3);

        // R4: busy mode set and refresh
        step(K_MRS, 1, 0, 0, 2, 0);
        chk("R4 mode set busy", int'(viol_code_o), 1);
        step(K_RD, 1, 0, 0, 0, 0);
        chk("R4 rejected mode set starts no gap", int'(viol_o), 0);
        step(K_REF, 1, 0, 0, 0, 0);
        chk("R4 refresh busy", int'(viol_code_o), 2);

        // R3: single and all-bank precharge
        step(K_PRE, 1, 0, 0, 0, 0);
        chk("R3 single bank", int'(bank_act_o), 2);
        step(K_PRE, 1, 0, 1, 0, 0);
        chk("R3 both banks", int'(bank_act_o), 0);

        // R5: command gap after a mode set (burst length 4)
        step(K_MRS, 1, 0, 0, 2, 0);
        chk("R5 mode set accepted", int'(viol_o), 0);
        step(K_ACT, 1, 0, 0, 5, 0);
        chk("R5 gap cycle 1", int'(viol_code_o), 3);
        step(K_ACT, 1, 0, 0, 5, 0);
        chk("R5 gap cycle 2", int'(viol_code_o), 3);
        chk("R5 gap ignored", int'(bank_act_o), 0);
        step(K_ACT, 1, 0, 0, 5, 0);
        chk("R5 after gap", int'(bank_act_o), 1);

        // R6 / R7: self-closing burst of 4
        step(K_RD, 1, 0, 1, 0, 0);
        step(K_RD, 1, 0, 0, 0, 0);
        chk("R7 same bank", int'(viol_code_o), 4);
        step(K_WR, 1, 1, 0, 0, 0);
        chk("R7 other bank", int'(viol_o), 0);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R6 open before boundary", int'(bank_act_o[0]), 1);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R6 closed at boundary", int'(bank_act_o[0]), 0);

        // R8 / R9: DQM latencies
        step(K_NOP, 1, 0, 0, 0, 1);
        chk("R8 write mask same cycle", int'(wr_mask_o), 1);
        chk("R9 not yet", int'(rd_hiz_o), 0);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R8 mask released", int'(wr_mask_o), 0);
        chk("R9 not yet", int'(rd_hiz_o), 0);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R9 output disabled", int'(rd_hiz_o), 1);

        // R10: power states
        step(K_NOP, 0, 0, 0, 0, 0);
        chk("R10 power-down", int'(pwr_o), 2);
        step(K_ACT, 0, 0, 0, 7, 0);
        chk("R10 ignored while low", int'(bank_act_o), 0);
        chk("R10 reports no-op", int'(cmd_o), 0);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R10 exit", int'(pwr_o), 0);
        step(K_ACT, 1, 0, 0, 9, 0);
        step(K_NOP, 0, 0, 0, 0, 0);
        chk("R10 suspend", int'(pwr_o), 1);
        step(K_NOP, 1, 0, 0, 0, 0);
        step(K_REF, 0, 0, 0, 0, 0);
        chk("R10 R4 self refresh busy", int'(viol_code_o), 2);
        chk("R10 R4 suspend instead", int'(pwr_o), 1);
        step(K_NOP, 1, 0, 0, 0, 0);
        step(K_PRE, 1, 0, 1, 0, 0);
        step(K_REF, 0, 0, 0, 0, 0);
        chk("R10 self refresh", int'(pwr_o), 3);
        chk("R10 self refresh code", int'(cmd_o), 3);
        step(K_NOP, 0, 0, 0, 0, 0);
        chk("R10 stays", int'(pwr_o), 3);
        step(K_NOP, 1, 0, 0, 0, 0);
        chk("R10 leaves self refresh", int'(pwr_o), 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r, k;
            r = $urandom_range(0, 99);
            if (r < 10) k = K_DES;
            else if (r < 13) k = K_MRS;
            else if (r < 18) k = K_REF;
            else if (r < 36) k = K_ACT;
            else if (r < 51) k = K_RD;
            else if (r < 64) k = K_WR;
            else if (r < 68) k = K_BST;
            else if (r < 82) k = K_PRE;
            else k = K_NOP;
            step(k, $urandom_range(0, 99) >= 7, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
                 $urandom_range(0, 3) == 0);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule